// File: doc/BRIEF.md
# Permuted-Quadrant 8-Point Integer DCT Unit

This block turns one vector of eight signed samples per clock into its one-dimensional 8-point integer DCT, either forward or inverse. The direction is chosen by an input sampled with each vector. It is meant to sit on one axis of a two-dimensional transform in a high-fidelity video codec. Transposition, scaling and rounding to the codec's final precision are left to the surrounding logic.

The datapath never multiplies. A fixed reordering of the inputs, made only of wires, turns the 8x8 coefficient matrix into four 4x4 quadrants. Each quadrant has the same shape: every row is either symmetric (p, q, q, p) or antisymmetric (p, q, -q, -p). Each quadrant is evaluated by a small butterfly whose constants are built from shifts and adds. The forward transform runs that butterfly on its input side. The inverse transform uses the transposed form, which runs the same constants on the output side. Quadrant results are then added in pairs. All values are kept as integers in units of 1/8, so the fractional constants are exact.

Top module: `dct8_unit`

## Requirements
- R1: In forward mode the result is out[k] = sum over n of C[k][n]*in[n], exact and in units of 1/8. The rows of C (k = 0..7, n = 0..7) are: [8 8 8 8 8 8 8 8], [12 10 6 3 -3 -6 -10 -12], [8 4 -4 -8 -8 -4 4 8], [10 -3 -12 -6 6 12 3 -10], [8 -8 -8 8 8 -8 -8 8], [6 -12 3 10 -10 -3 12 -6], [4 -8 8 -4 -4 8 -8 4] and [3 -6 10 -12 12 -10 6 -3]. Lane i of each bus occupies bits [i*W +: W], with lane 0 in the least significant bits, and every lane is two's complement.
- R2: In inverse mode (inverse = 1) the result uses the transposed matrix: out[n] = sum over k of C[k][n]*in[k]. In particular, an input with only lane 0 nonzero gives 8*in[0] on all eight outputs.
- R3: validOut is high in the cycle after each clock edge at which validIn was high, and low otherwise. The result for a vector taken at an edge is on dataOut right after that edge.
- R4: While validIn is low, dataOut keeps the last result. The data and inverse inputs have no effect in those cycles.
- R5: The direction is taken per vector. Back-to-back vectors with different directions each give the correct result.
- R6: While reset is held, validOut is 0 and every dataOut lane is 0.
- R7: Output lanes are IN_W+7 bits wide. Inputs at full scale (+32767 or -32768 for IN_W = 16), in the sign pattern that maximizes any output, give exact results with no wrap.
- R8: A forward vector with all eight lanes equal to c gives 64*c on lane 0 and 0 on lanes 1 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Accept the vector on dataIn at this edge |
| inverse | input | 1 | 1 selects the inverse transform, 0 the forward transform |
| dataIn | input | 8*IN_W | Eight signed input lanes, lane 0 in the LSBs |
| validOut | output | 1 | dataOut holds a result accepted at the previous edge |
| dataOut | output | 8*(IN_W+7) | Eight signed result lanes in natural order, in units of 1/8 |

## Verification
Single-lane impulses of both signs at each of the eight positions, in both directions, read out every column and row of the matrix. They catch a wrong coefficient, sign or lane routing in one quadrant that dense data could hide. Full-scale vectors whose signs follow each row (forward) or column (inverse) drive every output to its largest magnitude, which shows that the widths do not wrap. Constant vectors check the forward DC case. A long pseudo-random stream that mixes directions back to back, with idle gaps in which the direction input toggles, separates per-vector direction handling from any leftover state and confirms that outputs hold between vectors.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;         // capture the quadrant results this cycle
    logic inverseIn;    // direction of the vector being captured
    logic inverseHeld;  // direction of the result held in the register
  } dctStrobe_t;

  // Wire reordering that regularizes the forward matrix: sample r moves to slot permTarget(r).
  function automatic int permTarget(input int r);
    case (r)
      0: return 0;
      1: return 4;
      2: return 5;
      3: return 1;
      4: return 2;
      5: return 6;
      6: return 7;
      default: return 3;
    endcase
  endfunction

  // Inverse of permTarget: the sample that lands in slot j.
  function automatic int permSource(input int j);
    int src;
    src = 0;
    for (int r = 0; r < 8; r++)
      if (permTarget(r) == j) src = r;
    return src;
  endfunction

  // Each quadrant row has the form (p, q, q, p) on even rows or (p, q, -q, -p) on odd rows.
  // Quadrant 0 and 1 feed the upper output rows; 2 and 3 the lower; 0 and 2 take slots 0..3.
  function automatic int coefP(input int quad, input int row);
    case (quad * 4 + row)
      0: return 8;   1: return 12;  2: return 8;   3: return 10;
      4: return 8;   5: return 10;  6: return 4;   7: return -3;
      8: return 8;   9: return 6;   10: return 4;  11: return 3;
      12: return -8; 13: return -12; 14: return -8; default: return -6;
    endcase
  endfunction

  function automatic int coefQ(input int quad, input int row);
    case (quad * 4 + row)
      0: return 8;   1: return 3;   2: return -8;  3: return -6;
      4: return 8;   5: return 6;   6: return -4;  7: return -12;
      8: return 8;   9: return 10;  10: return -4; 11: return -12;
      12: return -8; 13: return 3;  14: return 8;  default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/dct8_quad.sv
module dct8_quad #(
  parameter int QIDX = 0,
  parameter int IN_W = 16
) (
  input  logic                   inverse,
  input  logic signed [IN_W-1:0] a [4],
  output logic signed [IN_W+5:0] y [4]
);
  import dct8_pkg::*;

  localparam int QW = IN_W + 6;

  // Constant multiply for the magnitudes the quadrants use, built from shifts and adds.
  function automatic logic signed [QW-1:0] mulc(input int k, input logic signed [QW-1:0] x);
    logic signed [QW-1:0] t;
    int mag;
    mag = (k < 0) ? -k : k;
    case (mag)
      3:       t = (x <<< 1) + x;
      4:       t = x <<< 2;
      6:       t = (x <<< 2) + (x <<< 1);
      8:       t = x <<< 3;
      10:      t = (x <<< 3) + (x <<< 1);
      12:      t = (x <<< 3) + (x <<< 2);
      default: t = '0;
    endcase
    return (k < 0) ? -t : t;
  endfunction

  logic signed [QW-1:0] ext [4];
  logic signed [QW-1:0] sumOuter, difOuter, sumInner, difInner;
  logic signed [QW-1:0] fwdRes [4];
  logic signed [QW-1:0] pSym, pAnti, qSym, qAnti;
  logic signed [QW-1:0] invRes [4];

  always_comb begin
    for (int i = 0; i < 4; i++)
      ext[i] = {{(QW-IN_W){a[i][IN_W-1]}}, a[i]};

    // Forward: butterfly before the constants.
    sumOuter = ext[0] + ext[3];
    difOuter = ext[0] - ext[3];
    sumInner = ext[1] + ext[2];
    difInner = ext[1] - ext[2];
    for (int r = 0; r < 4; r++) begin
      if (r % 2 == 0)
        fwdRes[r] = mulc(coefP(QIDX, r), sumOuter) + mulc(coefQ(QIDX, r), sumInner);
      else
        fwdRes[r] = mulc(coefP(QIDX, r), difOuter) + mulc(coefQ(QIDX, r), difInner);
    end

    // Inverse: the same constants, butterfly after them (transposed quadrant).
    pSym  = mulc(coefP(QIDX, 0), ext[0]) + mulc(coefP(QIDX, 2), ext[2]);
    pAnti = mulc(coefP(QIDX, 1), ext[1]) + mulc(coefP(QIDX, 3), ext[3]);
    qSym  = mulc(coefQ(QIDX, 0), ext[0]) + mulc(coefQ(QIDX, 2), ext[2]);
    qAnti = mulc(coefQ(QIDX, 1), ext[1]) + mulc(coefQ(QIDX, 3), ext[3]);
    invRes[0] = pSym + pAnti;
    invRes[1] = qSym + qAnti;
    invRes[2] = qSym - qAnti;
    invRes[3] = pSym - pAnti;

    for (int r = 0; r < 4; r++)
      y[r] = inverse ? invRes[r] : fwdRes[r];
  end

endmodule

// File: rtl/dct8_ctrl.sv
module dct8_ctrl
  import dct8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  logic       inverse,
  output dctStrobe_t strobe,
  output logic       validOut
);

  logic heldInverse;

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut    <= 1'b0;
      heldInverse <= 1'b0;
    end else begin
      validOut <= validIn;
      if (validIn) heldInverse <= inverse;
    end
  end

  always_comb begin
    strobe.load        = validIn;
    strobe.inverseIn   = inverse;
    strobe.inverseHeld = heldInverse;
  end

  // R3
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst) validIn |=> validOut);
  // R3
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst) !validIn |=> !validOut);

endmodule

// File: rtl/dct8_datapath.sv
module dct8_datapath
  import dct8_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dctStrobe_t              strobe,
  input  logic [8*IN_W-1:0]       dataIn,
  output logic [8*(IN_W+7)-1:0]   dataOut
);

  localparam int QW = IN_W + 6;
  localparam int OW = IN_W + 7;

  logic signed [IN_W-1:0] lane     [8];
  logic signed [IN_W-1:0] quadIn   [4][4];
  logic signed [QW-1:0]   quadOut  [4][4];
  logic signed [QW-1:0]   quadReg  [4][4];
  logic signed [OW-1:0]   sumFwd   [8];
  logic signed [OW-1:0]   sumInv   [8];
  logic signed [OW-1:0]   result   [8];

  for (genvar i = 0; i < 8; i++) begin : g_unpack
    assign lane[i] = dataIn[i*IN_W +: IN_W];
  end

  // Routing: forward uses the reordered slots, inverse splits the natural halves.
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      quadIn[0][i] = strobe.inverseIn ? lane[i]     : lane[permSource(i)];
      quadIn[1][i] = strobe.inverseIn ? lane[i]     : lane[permSource(4 + i)];
      quadIn[2][i] = strobe.inverseIn ? lane[4 + i] : lane[permSource(i)];
      quadIn[3][i] = strobe.inverseIn ? lane[4 + i] : lane[permSource(4 + i)];
    end
  end

  for (genvar q = 0; q < 4; q++) begin : g_quad
    dct8_quad #(.QIDX(q), .IN_W(IN_W)) uQuad (
      .inverse (strobe.inverseIn),
      .a       (quadIn[q]),
      .y       (quadOut[q])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < 4; q++)
        for (int r = 0; r < 4; r++)
          quadReg[q][r] <= '0;
    end else if (strobe.load) begin
      quadReg <= quadOut;
    end
  end

  // Pairwise quadrant sums, then the output reorder for the inverse direction.
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      sumFwd[r]     = {quadReg[0][r][QW-1], quadReg[0][r]} + {quadReg[1][r][QW-1], quadReg[1][r]};
      sumFwd[4 + r] = {quadReg[2][r][QW-1], quadReg[2][r]} + {quadReg[3][r][QW-1], quadReg[3][r]};
      sumInv[r]     = {quadReg[0][r][QW-1], quadReg[0][r]} + {quadReg[2][r][QW-1], quadReg[2][r]};
      sumInv[4 + r] = {quadReg[1][r][QW-1], quadReg[1][r]} + {quadReg[3][r][QW-1], quadReg[3][r]};
    end
    for (int n = 0; n < 8; n++)
      result[n] = strobe.inverseHeld ? sumInv[permTarget(n)] : sumFwd[n];
  end

  for (genvar i = 0; i < 8; i++) begin : g_pack
    assign dataOut[i*OW +: OW] = result[i];
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst) !strobe.load |=> $stable(dataOut));

endmodule

// File: rtl/dct8_unit.sv
module dct8_unit
  import dct8_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  validIn,
  input  logic                  inverse,
  input  logic [8*IN_W-1:0]     dataIn,
  output logic                  validOut,
  output logic [8*(IN_W+7)-1:0] dataOut
);

  localparam int OW = IN_W + 7;

  dctStrobe_t strobe;

  dct8_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .inverse  (inverse),
    .strobe   (strobe),
    .validOut (validOut)
  );

  dct8_datapath #(.IN_W(IN_W)) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  // Observation signals for the assertions below.
  logic signed [IN_W-1:0] inLane  [8];
  logic signed [OW-1:0]   outLane [8];
  logic signed [OW-1:0]   dcExpect, impulseExpect;
  logic inAllSame, inRestZero, outAllSame, outRestZero;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      inLane[i]  = dataIn[i*IN_W +: IN_W];
      outLane[i] = dataOut[i*OW +: OW];
    end
    inAllSame = 1'b1; inRestZero = 1'b1; outAllSame = 1'b1; outRestZero = 1'b1;
    for (int i = 1; i < 8; i++) begin
      if (inLane[i] != inLane[0])   inAllSame   = 1'b0;
      if (inLane[i] != '0)          inRestZero  = 1'b0;
      if (outLane[i] != outLane[0]) outAllSame  = 1'b0;
      if (outLane[i] != '0)         outRestZero = 1'b0;
    end
    dcExpect      = {{7{inLane[0][IN_W-1]}}, inLane[0]} <<< 6;
    impulseExpect = {{7{inLane[0][IN_W-1]}}, inLane[0]} <<< 3;
  end

  // R8
  dc_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (validIn && !inverse && inAllSame) |=> (outLane[0] == $past(dcExpect)) && outRestZero);
  // R2
  impulse_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (validIn && inverse && inRestZero) |=> outAllSame && (outLane[0] == $past(impulseExpect)));

endmodule

// File: tb/dct8_unit_test.sv
module dct8_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 16;
  localparam int OW = IN_W + 7;
  localparam int CTAB [64] = '{
     8,   8,   8,   8,   8,   8,   8,   8,
    12,  10,   6,   3,  -3,  -6, -10, -12,
     8,   4,  -4,  -8,  -8,  -4,   4,   8,
    10,  -3, -12,  -6,   6,  12,   3, -10,
     8,  -8,  -8,   8,   8,  -8,  -8,   8,
     6, -12,   3,  10, -10,  -3,  12,  -6,
     4,  -8,   8,  -4,  -4,   8,  -8,   4,
     3,  -6,  10, -12,  12, -10,   6,  -3 };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic inverse = 1'b0;
  logic [8*IN_W-1:0] dataIn = '0;
  logic validOut;
  logic [8*OW-1:0] dataOut;

  int nChecks = 0;
  int nErrors = 0;
  int expOut [8] = '{default: 0};
  logic expValid = 1'b0;
  string expTag = "R6 reset";
  logic [31:0] lfsr = 32'h1357_9bdf;

  dct8_unit #(.IN_W(IN_W)) uut (
    .clk(clk), .rst(rst), .validIn(validIn), .inverse(inverse),
    .dataIn(dataIn), .validOut(validOut), .dataOut(dataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int cv(input int k, input int n);
    return CTAB[k*8 + n];
  endfunction

  task automatic checkNow();
    int got;
    bit bad;
    nChecks++;
    if (validOut !== expValid) begin
      nErrors++;
      $display("FAIL R3 validOut got %0b exp %0b", validOut, expValid);
    end
    nChecks++;
    bad = 1'b0;
    for (int i = 0; i < 8; i++) begin
      got = int'($signed(dataOut[i*OW +: OW]));
      if (got != expOut[i] && !bad) begin
        bad = 1'b1;
        $display("FAIL %s lane %0d got %0d exp %0d", expTag, i, got, expOut[i]);
      end
    end
    if (bad) nErrors++;
  endtask

  task automatic step(input logic v, input logic d, input int vec [8], input string tag);
    int acc;
    @(negedge clk);
    checkNow();
    validIn = v;
    inverse = d;
    for (int i = 0; i < 8; i++) dataIn[i*IN_W +: IN_W] = IN_W'(vec[i]);
    expValid = v;
    if (v) begin
      expTag = tag;
      for (int k = 0; k < 8; k++) begin
        acc = 0;
        for (int n = 0; n < 8; n++) acc += (d ? cv(n, k) : cv(k, n)) * vec[n];
        expOut[k] = acc;
      end
    end else begin
      expTag = "R4 hold";
    end
  endtask

  task automatic nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin : main
    int v [8];
    int cval [5];
    cval = '{1, -1, 32767, -32768, 1234};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R6 reset state is checked by the first step; R1 / R2 impulses at every lane
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 8; p++)
        for (int s = 0; s < 2; s++) begin
          for (int i = 0; i < 8; i++) v[i] = 0;
          v[p] = s ? -32768 : 32767;
          step(1'b1, d[0], v, d ? "R2 impulse" : "R1 impulse");
        end

    // R7 full-scale sign patterns that maximize each output, both polarities
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 8; k++)
        for (int s = 0; s < 2; s++) begin
          for (int n = 0; n < 8; n++)
            v[n] = (((d ? cv(n, k) : cv(k, n)) >= 0) ^ s[0]) ? 32767 : -32768;
          step(1'b1, d[0], v, "R7 full-scale");
        end

    // R8 forward DC
    for (int c = 0; c < 5; c++) begin
      for (int i = 0; i < 8; i++) v[i] = cval[c];
      step(1'b1, 1'b0, v, "R8 dc");
    end

    // R4 idle cycles with toggling direction and changing data
    for (int i = 0; i < 8; i++) v[i] = i * 100 - 350;
    step(1'b1, 1'b1, v, "R2 ramp");
    for (int g = 0; g < 4; g++) begin
      for (int i = 0; i < 8; i++) v[i] = 9999 - g * 77 * i;
      step(1'b0, g[0], v, "");
    end

    // R5 mixed directions back to back, with occasional idle gaps (R4)
    for (int t = 0; t < 1500; t++) begin
      for (int i = 0; i < 8; i++) begin
        nextRand();
        v[i] = int'($signed(lfsr[15:0]));
      end
      nextRand();
      step(lfsr[3:0] != 4'd0, lfsr[7], v, lfsr[7] ? "R5 mixed inverse" : "R5 mixed forward");
    end

    for (int i = 0; i < 8; i++) v[i] = 0;
    step(1'b0, 1'b0, v, "");
    step(1'b0, 1'b1, v, "");
    @(negedge clk);
    checkNow();

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule